// File: doc/BRIEF.md
# Calendar Time Counter with BCD and Binary Counting

This block keeps wall-clock time and date in seven byte-wide registers: seconds, minutes, hours, weekday, day of month, month and two-digit year. Each pulse on a one-second strobe advances the time by one second. A carry ripples from seconds through minutes and hours into the date fields in that same cycle.

Two static inputs select how the bytes are coded. The first picks packed two-digit decimal (BCD) or plain binary. The second picks a 24-hour or a 12-hour clock; in 12-hour mode the hours byte carries an afternoon flag in its top bit. A hold input freezes counting while software loads a new time. Each register can be written directly through a select-and-data port. The block has no strobe generator, alarm compare, daylight-saving logic or scratch RAM.

Top module: `cal_time_counter`

## Requirements
- R1: After synchronous reset the registers read seconds 0, minutes 0, hours 0, weekday 1, day 1, month 1, year 0.
- R2: With `bin_fmt`=0 every register holds two decimal digits (tens in bits 7:4, units in bits 3:0). Seconds and minutes run 00 to 59, and each wrap carries into the next field (for example 09 steps to 10, and 59 wraps to 00).
- R3: With `bin_fmt`=1 the same ranges are counted as plain binary values (for example 9 steps to 0x0A, and 59 = 0x3B wraps to 0).
- R4: With `hr24_fmt`=1 hours run 0 to 23, and the wrap from 23 produces the day carry.
- R5: With `hr24_fmt`=0, hours bits 6:0 run 0 to 11 and bit 7 is the afternoon flag. A wrap of bits 6:0 toggles bit 7, and only the wrap with bit 7 set produces the day carry.
- R6: The weekday runs 1 to 7 and advances on the day carry, wrapping 7 to 1. Its wrap carries into no other field.
- R7: The day of month runs from 1 to the month length: 31 for months 1, 3, 5, 7, 8, 10 and 12, 30 for months 4, 6, 9 and 11, 29 for month 2 when the year is a multiple of 4, and 28 otherwise. The check uses the numeric month and year in either coding.
- R8: The month runs 1 to 12 on the day-of-month carry, and its wrap advances the year, which runs 0 to 99 and wraps to 0.
- R9: While `set_hold`=1, a strobe leaves every register unchanged.
- R10: A write with `wr_en`=1 stores `wr_data` in the register picked by `wr_sel` (0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year). Select values 7 to 15 change nothing.
- R11: A write in the same cycle as a strobe wins: the written value is stored and that strobe is discarded for every register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-second advance strobe, one cycle wide |
| set_hold | input | 1 | Freeze counting while high |
| bin_fmt | input | 1 | 1 = binary coding, 0 = BCD coding |
| hr24_fmt | input | 1 | 1 = 24-hour clock, 0 = 12-hour clock with afternoon flag |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select for a write |
| wr_data | input | 8 | Write data |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours |
| wday_o | output | 8 | Weekday |
| mday_o | output | 8 | Day of month |
| mon_o | output | 8 | Month |
| year_o | output | 8 | Year |

## Verification
Several properties hold on every cycle. The hold input freezes all seven registers. A write lands in the selected register and beats a simultaneous strobe. Seconds wrap from 59 in both codings, and hours fall to 0 at 23:59:59 in 24-hour mode. Other behaviour can only be shown by the bench's scenarios, because it depends on a specific calendar position: month lengths and the leap rule, weekday wrap without a carry, the afternoon flag toggling in 12-hour mode, and the full rollover at the end of a year.

// File: rtl/cal_time_pkg.sv
package cal_time_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned SEL_W  = 4;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_SEC  = 4'd0,
        SEL_MIN  = 4'd1,
        SEL_HOUR = 4'd2,
        SEL_WDAY = 4'd3,
        SEL_MDAY = 4'd4,
        SEL_MON  = 4'd5,
        SEL_YEAR = 4'd6
    } cal_sel_e;

    typedef struct packed {
        byte_t sec;
        byte_t min;
        byte_t hour;
        byte_t wday;
        byte_t mday;
        byte_t mon;
        byte_t year;
    } cal_time_t;

    localparam byte_t SEC_LAST  = 8'd59;
    localparam byte_t MIN_LAST  = 8'd59;
    localparam byte_t H24_LAST  = 8'd23;
    localparam byte_t H12_LAST  = 8'd11;
    localparam byte_t WDAY_LAST = 8'd7;
    localparam byte_t MON_LAST  = 8'd12;
    localparam byte_t YEAR_LAST = 8'd99;

    localparam cal_time_t RESET_TIME = '{sec: 8'd0, min: 8'd0, hour: 8'd0,
                                         wday: 8'd1, mday: 8'd1, mon: 8'd1,
                                         year: 8'd0};

    // Numeric value of a stored byte under the selected coding.
    function automatic byte_t to_num(input logic bcd, input byte_t v);
        byte_t tens;
        tens = {4'd0, v[7:4]};
        return bcd ? (tens * 8'd10 + {4'd0, v[3:0]}) : v;
    endfunction

    // Stored form of a numeric value under the selected coding.
    function automatic byte_t from_num(input logic bcd, input byte_t n);
        byte_t q;
        byte_t r;
        q = n / 8'd10;
        r = n % 8'd10;
        return bcd ? {q[3:0], r[3:0]} : n;
    endfunction

    function automatic logic at_last(input logic bcd, input byte_t v, input byte_t last);
        return to_num(bcd, v) >= last;
    endfunction

    function automatic byte_t month_days(input byte_t mon_n, input byte_t year_n);
        byte_t d;
        case (mon_n)
            8'd2:                    d = (year_n[1:0] == 2'd0) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11: d = 8'd30;
            default:                 d = 8'd31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/cal_field_step.sv
module cal_field_step
    import cal_time_pkg::*;
(
    input  logic  bcd,
    input  logic  adv,
    input  byte_t cur,
    input  byte_t first,
    input  byte_t last,
    output byte_t nxt
);
    byte_t num;

    always_comb begin
        num = to_num(bcd, cur);
        if (!adv) begin
            nxt = cur;
        end else if (num >= last) begin
            nxt = from_num(bcd, first);
        end else begin
            nxt = from_num(bcd, num + 8'd1);
        end
    end

endmodule

// File: rtl/cal_hour_step.sv
module cal_hour_step
    import cal_time_pkg::*;
(
    input  logic  bcd,
    input  logic  hr24,
    input  logic  adv,
    input  byte_t cur,
    output byte_t nxt,
    output logic  day_carry
);
    byte_t low7;
    byte_t n24;
    byte_t n12;
    logic  wrap24;
    logic  wrap12;

    assign low7 = {1'b0, cur[6:0]};

    cal_field_step u_step24 (
        .bcd   (bcd),
        .adv   (adv),
        .cur   (cur),
        .first (8'd0),
        .last  (H24_LAST),
        .nxt   (n24)
    );

    cal_field_step u_step12 (
        .bcd   (bcd),
        .adv   (adv),
        .cur   (low7),
        .first (8'd0),
        .last  (H12_LAST),
        .nxt   (n12)
    );

    assign wrap24 = adv & at_last(bcd, cur, H24_LAST);
    assign wrap12 = adv & at_last(bcd, low7, H12_LAST);

    always_comb begin
        if (hr24) begin
            nxt       = n24;
            day_carry = wrap24;
        end else begin
            // afternoon flag toggles on each wrap of the 0..11 count
            nxt       = {cur[7] ^ wrap12, 7'd0} | (n12 & 8'h7F);
            day_carry = wrap12 & cur[7];
        end
    end

endmodule

// File: rtl/cal_time_counter.sv
module cal_time_counter
    import cal_time_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_1hz,
    input  logic       set_hold,
    input  logic       bin_fmt,
    input  logic       hr24_fmt,
    input  logic       wr_en,
    input  logic [3:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] wday_o,
    output logic [7:0] mday_o,
    output logic [7:0] mon_o,
    output logic [7:0] year_o
);
    cal_time_t cur;
    byte_t     n_sec, n_min, n_hour, n_wday, n_mday, n_mon, n_year;
    byte_t     mon_n, year_n, mlen;
    logic      bcd, adv;
    logic      c_min, c_hour, c_day, c_mon, c_year;

    assign bcd = ~bin_fmt;
    assign adv = tick_1hz & ~set_hold;

    // carry chain, all resolved in the strobe cycle
    assign c_min  = adv & at_last(bcd, cur.sec, SEC_LAST);
    assign c_hour = c_min & at_last(bcd, cur.min, MIN_LAST);

    cal_field_step u_sec (
        .bcd (bcd), .adv (adv), .cur (cur.sec),
        .first (8'd0), .last (SEC_LAST), .nxt (n_sec)
    );

    cal_field_step u_min (
        .bcd (bcd), .adv (c_min), .cur (cur.min),
        .first (8'd0), .last (MIN_LAST), .nxt (n_min)
    );

    cal_hour_step u_hour (
        .bcd       (bcd),
        .hr24      (hr24_fmt),
        .adv       (c_hour),
        .cur       (cur.hour),
        .nxt       (n_hour),
        .day_carry (c_day)
    );

    // weekday is a single digit in both codings and feeds no carry onward
    always_comb begin
        if (!c_day) begin
            n_wday = cur.wday;
        end else if (cur.wday >= WDAY_LAST) begin
            n_wday = 8'd1;
        end else begin
            n_wday = cur.wday + 8'd1;
        end
    end

    assign mon_n  = to_num(bcd, cur.mon);
    assign year_n = to_num(bcd, cur.year);
    assign mlen   = month_days(mon_n, year_n);

    assign c_mon  = c_day & at_last(bcd, cur.mday, mlen);
    assign c_year = c_mon & at_last(bcd, cur.mon, MON_LAST);

    cal_field_step u_mday (
        .bcd (bcd), .adv (c_day), .cur (cur.mday),
        .first (8'd1), .last (mlen), .nxt (n_mday)
    );

    cal_field_step u_mon (
        .bcd (bcd), .adv (c_mon), .cur (cur.mon),
        .first (8'd1), .last (MON_LAST), .nxt (n_mon)
    );

    cal_field_step u_year (
        .bcd (bcd), .adv (c_year), .cur (cur.year),
        .first (8'd0), .last (YEAR_LAST), .nxt (n_year)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= RESET_TIME;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_SEC:  cur.sec  <= wr_data;
                SEL_MIN:  cur.min  <= wr_data;
                SEL_HOUR: cur.hour <= wr_data;
                SEL_WDAY: cur.wday <= wr_data;
                SEL_MDAY: cur.mday <= wr_data;
                SEL_MON:  cur.mon  <= wr_data;
                SEL_YEAR: cur.year <= wr_data;
                default:  ;
            endcase
        end else if (adv) begin
            cur <= '{sec: n_sec, min: n_min, hour: n_hour, wday: n_wday,
                     mday: n_mday, mon: n_mon, year: n_year};
        end
    end

    assign sec_o  = cur.sec;
    assign min_o  = cur.min;
    assign hour_o = cur.hour;
    assign wday_o = cur.wday;
    assign mday_o = cur.mday;
    assign mon_o  = cur.mon;
    assign year_o = cur.year;

endmodule

// File: rtl/cal_time_counter_chk.sv
module cal_time_counter_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick_1hz,
    input logic       set_hold,
    input logic       bin_fmt,
    input logic       hr24_fmt,
    input logic       wr_en,
    input logic [3:0] wr_sel,
    input logic [7:0] wr_data,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hour_o,
    input logic [7:0] wday_o,
    input logic [7:0] mday_o,
    input logic [7:0] mon_o,
    input logic [7:0] year_o
);
    logic [55:0] all_regs;
    assign all_regs = {sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o};

    // R9
    hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_1hz && set_hold && !wr_en) |=> $stable(all_regs));

    // R11
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 4'd0) |=> (sec_o == $past(wr_data)));

    // R2
    bcd_sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_1hz && !set_hold && !wr_en && !bin_fmt && sec_o == 8'h59)
        |=> (sec_o == 8'h00));

    // R3
    bin_sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_1hz && !set_hold && !wr_en && bin_fmt && sec_o == 8'd59)
        |=> (sec_o == 8'h00));

    // R4
    day24_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_1hz && !set_hold && !wr_en && !bin_fmt && hr24_fmt &&
         hour_o == 8'h23 && min_o == 8'h59 && sec_o == 8'h59)
        |=> (hour_o == 8'h00));

endmodule

bind cal_time_counter cal_time_counter_chk i_cal_time_counter_chk (.*);

// File: tb/test_cal_time_counter.sv
`timescale 1ns/1ps
module test_cal_time_counter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0;
    logic       set_hold = 1'b0;
    logic       bin_fmt = 1'b0;
    logic       hr24_fmt = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_sel = 4'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0]  e [7];
    logic [55:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    cal_time_counter i_cal_time_counter (
        .clk (clk), .rst (rst), .tick_1hz (tick_1hz), .set_hold (set_hold),
        .bin_fmt (bin_fmt), .hr24_fmt (hr24_fmt), .wr_en (wr_en),
        .wr_sel (wr_sel), .wr_data (wr_data),
        .sec_o (sec_o), .min_o (min_o), .hour_o (hour_o), .wday_o (wday_o),
        .mday_o (mday_o), .mon_o (mon_o), .year_o (year_o)
    );

    // monitor: pops expected snapshots and compares away from the edge
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                logic [55:0] ex;
                logic [55:0] act;
                string       tg;
                ex  = exp_q.pop_front();
                tg  = tag_q.pop_front();
                act = {sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o};
                checks++;
                if (act !== ex) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", tg, act, ex);
                end
            end
        end
    end

    task automatic push(input string tag);
        exp_q.push_back({e[0], e[1], e[2], e[3], e[4], e[5], e[6]});
        tag_q.push_back(tag);
    endtask

    task automatic drive(input logic t, input logic w, input logic [3:0] s,
                         input logic [7:0] d, input string tag);
        @(negedge clk);
        tick_1hz = t; wr_en = w; wr_sel = s; wr_data = d;
        @(posedge clk);
        #1;
        tick_1hz = 1'b0; wr_en = 1'b0;
        push(tag);
    endtask

    task automatic wr(input logic [3:0] s, input logic [7:0] d, input string tag);
        if (s < 4'd7) e[s] = d;
        drive(1'b0, 1'b1, s, d, tag);
    endtask

    task automatic load(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                        input logic [7:0] wd, input logic [7:0] md,
                        input logic [7:0] mo, input logic [7:0] y);
        wr(4'd0, s,  "R10 write sec");
        wr(4'd1, m,  "R10 write min");
        wr(4'd2, h,  "R10 write hour");
        wr(4'd3, wd, "R10 write weekday");
        wr(4'd4, md, "R10 write day");
        wr(4'd5, mo, "R10 write month");
        wr(4'd6, y,  "R10 write year");
    endtask

    task automatic tk(input string tag, input logic [7:0] s, input logic [7:0] m,
                      input logic [7:0] h, input logic [7:0] wd, input logic [7:0] md,
                      input logic [7:0] mo, input logic [7:0] y);
        e[0] = s; e[1] = m; e[2] = h; e[3] = wd; e[4] = md; e[5] = mo; e[6] = y;
        drive(1'b1, 1'b0, 4'd0, 8'd0, tag);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        e[0] = 8'h00; e[1] = 8'h00; e[2] = 8'h00; e[3] = 8'h01;
        e[4] = 8'h01; e[5] = 8'h01; e[6] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        drive(1'b0, 1'b0, 4'd0, 8'd0, "R1 reset state");

        // R2 BCD counting
        load(8'h58, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        tk("R2 bcd second step", 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        tk("R4 R6 R8 year-end rollover", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        load(8'h59, 8'h09, 8'h05, 8'h03, 8'h15, 8'h06, 8'h20);
        tk("R2 bcd digit carry", 8'h00, 8'h10, 8'h05, 8'h03, 8'h15, 8'h06, 8'h20);

        // R6 weekday wrap feeds nothing
        load(8'h59, 8'h59, 8'h23, 8'h07, 8'h10, 8'h03, 8'h30);
        tk("R6 weekday wrap alone", 8'h00, 8'h00, 8'h00, 8'h01, 8'h11, 8'h03, 8'h30);

        // R7 month lengths
        load(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
        tk("R7 leap feb 28 to 29", 8'h00, 8'h00, 8'h00, 8'h03, 8'h29, 8'h02, 8'h24);
        load(8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24);
        tk("R7 leap feb end", 8'h00, 8'h00, 8'h00, 8'h04, 8'h01, 8'h03, 8'h24);
        load(8'h59, 8'h59, 8'h23, 8'h04, 8'h28, 8'h02, 8'h23);
        tk("R7 common feb end", 8'h00, 8'h00, 8'h00, 8'h05, 8'h01, 8'h03, 8'h23);
        load(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h04, 8'h23);
        tk("R7 30-day month end", 8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h05, 8'h23);
        load(8'h59, 8'h59, 8'h23, 8'h06, 8'h30, 8'h01, 8'h23);
        tk("R7 31-day month day 30", 8'h00, 8'h00, 8'h00, 8'h07, 8'h31, 8'h01, 8'h23);

        // R3 binary counting
        bin_fmt = 1'b1;
        load(8'h3B, 8'h3B, 8'h17, 8'h03, 8'h1F, 8'h0C, 8'h63);
        tk("R3 R8 binary year-end", 8'h00, 8'h00, 8'h00, 8'h04, 8'h01, 8'h01, 8'h00);
        load(8'h09, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        tk("R3 binary 9 to 10", 8'h0A, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        bin_fmt = 1'b0;

        // R5 12-hour mode
        hr24_fmt = 1'b0;
        load(8'h59, 8'h59, 8'h11, 8'h01, 8'h10, 8'h01, 8'h05);
        tk("R5 morning to afternoon", 8'h00, 8'h00, 8'h80, 8'h01, 8'h10, 8'h01, 8'h05);
        load(8'h59, 8'h59, 8'h85, 8'h01, 8'h10, 8'h01, 8'h05);
        tk("R5 afternoon hour step", 8'h00, 8'h00, 8'h86, 8'h01, 8'h10, 8'h01, 8'h05);
        load(8'h59, 8'h59, 8'h91, 8'h01, 8'h10, 8'h01, 8'h05);
        tk("R5 night to next day", 8'h00, 8'h00, 8'h00, 8'h02, 8'h11, 8'h01, 8'h05);
        hr24_fmt = 1'b1;

        // R9 hold
        load(8'h59, 8'h59, 8'h23, 8'h02, 8'h11, 8'h01, 8'h05);
        set_hold = 1'b1;
        drive(1'b1, 1'b0, 4'd0, 8'd0, "R9 strobe while held");
        drive(1'b1, 1'b0, 4'd0, 8'd0, "R9 second strobe while held");
        set_hold = 1'b0;

        // R11 write beats strobe
        load(8'h59, 8'h30, 8'h10, 8'h02, 8'h11, 8'h01, 8'h05);
        e[1] = 8'h44;
        drive(1'b1, 1'b1, 4'd1, 8'h44, "R11 write wins over strobe");
        tk("R2 R11 strobe after write", 8'h00, 8'h45, 8'h10, 8'h02, 8'h11, 8'h01, 8'h05);

        // R10 unused selects
        wr(4'd7,  8'hAA, "R10 select 7 ignored");
        wr(4'd15, 8'h55, "R10 select 15 ignored");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule